// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus-facing controller of a byte-wide nonvolatile memory of 4096 locations, reached over a two-wire (I2C-style) serial bus. The block samples SCL and SDA with a fast system clock and detects start and stop conditions. It compares each device byte with a fixed prefix and three strap inputs, so up to eight such devices can share one bus. It acknowledges bytes by pulling SDA low and otherwise leaves the line released.

A write loads a 12-bit word address from two header bytes. Data bytes then collect in a 32-byte page buffer, and the address counter wraps inside the current page. When the stop condition arrives, a self-timed commit copies the buffered bytes into the array. During that window the device ignores its own address, so a master can poll for completion. Reads return bytes from the word address counter, and a master acknowledge moves on to the next location. A write-permit input from protection logic can veto the commit. The array itself sits outside the block, behind a plain address, data and write-enable port.

Top module: `twi_eep_slave`

## Requirements
- R1: While reset is held, and afterwards on an idle bus, `sda_oe` is 0 and `mem_we` is 0.
- R2: A device byte is acknowledged only when its bits [7:4] equal 4'b1010 and its bits [3:1] equal `strap_sel`. Bit [0] selects the direction (1 = read). On a mismatch the byte and every later byte up to the next start condition get no acknowledge.
- R3: After an acknowledged write device byte, bits [3:0] of the first header byte become address bits [11:8], and the upper four bits are ignored. The second header byte becomes address bits [7:0]. Every header and data byte is acknowledged. The array is not written before the stop condition.
- R4: Consecutive data bytes go to successive addresses whose low 5 bits wrap within the 32-byte page while bits [11:5] stay fixed. Bytes beyond 32 overwrite earlier slots, the last value wins, and each written slot is stored exactly once. Locations outside the page are unchanged.
- R5: A stop that ends an accepted write starts a self-timed commit lasting `WRITE_CYCLES` clocks, and the array writes happen inside it. During the commit no device byte is acknowledged, and once it ends the device acknowledges again.
- R6: A read device byte returns the byte at the word address counter (current-address read). A random read sets the address with a write header followed by a repeated start. The counter advances after every byte read or written, so a read after a write starts at the next address.
- R7: In a read, a master acknowledge makes the slave send the byte at the next address, wrapping from 0xFFF to 0x000. A master non-acknowledge ends the read with SDA released.
- R8: If `wr_permit` is 0 at the stop condition, the header and data bytes are still acknowledged, but no array write and no commit window follow, and the next device byte is acknowledged at once.
- R9: The slave only pulls SDA low (`sda_oe` = 1) or releases it, and it changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_sel | input | 3 | Board-strapped device select bits |
| wr_permit | input | 1 | 1 allows a buffered page to be committed |
| mem_addr | output | 12 | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array write strobe, one byte per clock |
| mem_rdata | input | 8 | Array read data for `mem_addr`, combinational |

## Verification
The hardest state to reach from the ports is the commit window. It has to be probed with a device byte while the copy is still running, and the probe has to follow a page that wrapped and overwrote its own first slots. The bench shortens the commit to a thousand clocks. It sends a 34-byte page starting mid-page, then issues a start and a device byte straight after the stop to catch the non-acknowledge, and keeps polling until the device answers again. A sequential read across the whole page then shows which value each slot kept, and counting the write strobes shows each slot was stored once.

// File: rtl/twi_eep_pkg.sv
package twi_eep_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = 12;
  localparam int unsigned PW    = 5;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned PFX_W = DW - SEL_W - 1;
  localparam int unsigned NIB_W = AW - DW;
  localparam int unsigned SLOTS = 1 << PW;

  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_WAH, PH_WAL, PH_WDAT, PH_RDAT, PH_SKIP
  } twi_phase_e;

  // next address inside a page: upper part frozen, slot wraps
  function automatic logic [AW-1:0] page_step(input logic [AW-1:0] a);
    return {a[AW-1:PW], a[PW-1:0] + PW'(1)};
  endfunction

  // next address for reads: whole counter wraps
  function automatic logic [AW-1:0] seq_step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic dev_match(input logic [DW-1:0] b,
                                     input logic [PFX_W-1:0] pfx,
                                     input logic [SEL_W-1:0] sel);
    return b[DW-1:1] == {pfx, sel};
  endfunction
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int unsigned STAGES = 2
)(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign bus_start = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign bus_stop  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf
  import twi_eep_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_slot,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_slot,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          any_valid
);
  logic [DW-1:0]    store [SLOTS];
  logic [SLOTS-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_slot] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid_q <= '0;
    else if (clr)   valid_q <= '0;
    else if (wr_en) valid_q[wr_slot] <= 1'b1;
  end

  assign rd_data   = store[rd_slot];
  assign rd_valid  = valid_q[rd_slot];
  assign any_valid = |valid_q;
endmodule

// File: rtl/twi_commit_timer.sv
module twi_commit_timer
  import twi_eep_pkg::*;
#(
  parameter int unsigned CYCLES = 500000
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [AW-PW-1:0] page_base,
  input  logic [DW-1:0]    slot_data,
  input  logic             slot_valid,
  output logic [PW-1:0]    slot_idx,
  output logic             busy,
  output logic             done,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
  localparam logic [CW-1:0] COPY_END = CW'(SLOTS);

  logic [CW-1:0]    cnt_q;
  logic [AW-PW-1:0] page_q;
  logic             copy_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      page_q <= '0;
    end else if (go && !busy) begin
      busy   <= 1'b1;
      cnt_q  <= '0;
      page_q <= page_base;
    end else if (busy) begin
      if (cnt_q == LAST) busy <= 1'b0;
      else               cnt_q <= cnt_q + CW'(1);
    end
  end

  assign done      = busy && (cnt_q == LAST);
  assign copy_win  = busy && (cnt_q < COPY_END);
  assign slot_idx  = cnt_q[PW-1:0];
  assign mem_we    = copy_win && slot_valid;
  assign mem_addr  = {page_q, slot_idx};
  assign mem_wdata = slot_data;

  initial begin
    if (CYCLES < SLOTS) $error("commit window shorter than one page");
  end
endmodule

// File: rtl/twi_eep_slave.sv
module twi_eep_slave
  import twi_eep_pkg::*;
#(
  parameter logic [PFX_W-1:0] DEV_PREFIX   = 4'b1010,
  parameter int unsigned      WRITE_CYCLES = 500000,
  parameter int unsigned      SYNC_STAGES  = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [SEL_W-1:0] strap_sel,
  input  logic             wr_permit,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_we,
  input  logic [DW-1:0]    mem_rdata
);
  localparam int unsigned BIT_W = $clog2(DW + 2);
  localparam int unsigned TX_IW = $clog2(DW);
  localparam logic [BIT_W-1:0] ACK_BEG = BIT_W'(DW);
  localparam logic [BIT_W-1:0] ACK_END = BIT_W'(DW + 1);

  // line events
  logic scl_lvl, sda_lvl, ev_rise, ev_fall, ev_start, ev_stop;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(ev_rise), .scl_fall(ev_fall),
    .bus_start(ev_start), .bus_stop(ev_stop)
  );

  twi_phase_e       phase;
  logic [BIT_W-1:0] bit_idx;
  logic [DW-1:0]    shreg, tx_q;
  logic [AW-1:0]    word_addr;
  logic [NIB_W-1:0] hi_nib;
  logic             rw_q, dev_ok_q, mack_q;

  // named internal events
  logic byte_end_ev, slot_end_ev, dev_byte_ev, wbyte_ev, addr_hit, in_byte;
  logic commit_busy, commit_done, commit_go, buf_any, buf_clr;
  logic [PW-1:0]    cm_slot;
  logic [DW-1:0]    cm_data;
  logic             cm_valid, cm_we;
  logic [AW-1:0]    cm_addr;

  assign byte_end_ev = ev_fall && (bit_idx == ACK_BEG);
  assign slot_end_ev = ev_fall && (bit_idx == ACK_END);
  assign dev_byte_ev = byte_end_ev && (phase == PH_DEV);
  assign wbyte_ev    = byte_end_ev && (phase == PH_WDAT);
  assign addr_hit    = dev_match(shreg, DEV_PREFIX, strap_sel) && !commit_busy;
  assign in_byte     = (phase != PH_IDLE) && (phase != PH_SKIP);
  assign buf_clr     = (ev_start && !commit_busy) || commit_done;
  assign commit_go   = ev_stop && (phase == PH_WDAT) && buf_any && wr_permit && !commit_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bit_idx   <= '0;
      shreg     <= '0;
      tx_q      <= '0;
      word_addr <= '0;
      hi_nib    <= '0;
      rw_q      <= 1'b0;
      dev_ok_q  <= 1'b0;
      mack_q    <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (ev_stop) begin
      phase   <= PH_IDLE;
      bit_idx <= '0;
      sda_oe  <= 1'b0;
    end else if (ev_start) begin
      phase   <= PH_DEV;
      bit_idx <= '0;
      sda_oe  <= 1'b0;
    end else if (ev_rise && in_byte && (bit_idx < ACK_END)) begin
      bit_idx <= bit_idx + BIT_W'(1);
      if (bit_idx < ACK_BEG) shreg <= {shreg[DW-2:0], sda_lvl};
      else if (phase == PH_RDAT) mack_q <= !sda_lvl;
    end else if (byte_end_ev) begin
      unique case (phase)
        PH_DEV: begin
          sda_oe   <= addr_hit;
          dev_ok_q <= addr_hit;
          rw_q     <= shreg[0];
        end
        PH_WAH: begin
          sda_oe <= 1'b1;
          hi_nib <= shreg[NIB_W-1:0];
        end
        PH_WAL: begin
          sda_oe    <= 1'b1;
          word_addr <= {hi_nib, shreg};
        end
        PH_WDAT: begin
          sda_oe    <= 1'b1;
          word_addr <= page_step(word_addr);
        end
        PH_RDAT: begin
          sda_oe    <= 1'b0;
          word_addr <= seq_step(word_addr);
        end
        default: sda_oe <= 1'b0;
      endcase
    end else if (slot_end_ev) begin
      bit_idx <= '0;
      sda_oe  <= 1'b0;
      unique case (phase)
        PH_DEV: begin
          if (!dev_ok_q) phase <= PH_SKIP;
          else if (rw_q) begin
            phase  <= PH_RDAT;
            tx_q   <= mem_rdata;
            sda_oe <= !mem_rdata[DW-1];
          end else phase <= PH_WAH;
        end
        PH_WAH:  phase <= PH_WAL;
        PH_WAL:  phase <= PH_WDAT;
        PH_WDAT: phase <= PH_WDAT;
        PH_RDAT: begin
          if (mack_q) begin
            tx_q   <= mem_rdata;
            sda_oe <= !mem_rdata[DW-1];
          end else phase <= PH_SKIP;
        end
        default: phase <= phase;
      endcase
    end else if (ev_fall && (phase == PH_RDAT) && (bit_idx != '0) && (bit_idx < ACK_BEG)) begin
      sda_oe <= !tx_q[TX_IW'(DW - 1) - bit_idx[TX_IW-1:0]];
    end
  end

  twi_page_buf u_page (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr),
    .wr_en(wbyte_ev), .wr_slot(word_addr[PW-1:0]), .wr_data(shreg),
    .rd_slot(cm_slot), .rd_data(cm_data), .rd_valid(cm_valid),
    .any_valid(buf_any)
  );

  twi_commit_timer #(.CYCLES(WRITE_CYCLES)) u_commit (
    .clk(clk), .rst_n(rst_n), .go(commit_go),
    .page_base(word_addr[AW-1:PW]),
    .slot_data(cm_data), .slot_valid(cm_valid), .slot_idx(cm_slot),
    .busy(commit_busy), .done(commit_done),
    .mem_we(cm_we), .mem_addr(cm_addr), .mem_wdata(mem_wdata)
  );

  assign mem_we   = cm_we;
  assign mem_addr = commit_busy ? cm_addr : word_addr;

  // assertions
  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_byte_ev && commit_busy) |=> !sda_oe); // R5
  AST_NO_WE_DURING_RX: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (phase != PH_WDAT)); // R5
  AST_PAGE_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wbyte_ev |=> (word_addr[AW-1:PW] == $past(word_addr[AW-1:PW]))); // R4
  AST_DENIED_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !wr_permit && !commit_busy) |=> !commit_busy); // R8
  AST_OE_RISES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl); // R9
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP && $past(phase == PH_SKIP)) |-> !sda_oe); // R2
endmodule

// File: tb/test_twi_eep_slave.sv
`timescale 1ns/1ps
module test_twi_eep_slave;
  localparam int WCYC = 1000;
  localparam int Q    = 6;
  localparam logic [2:0] STRAP = 3'b101;
  localparam int NVEC = 6;
  // {address, data} byte-write vectors
  localparam logic [19:0] VEC [NVEC] = '{
    {12'h000, 8'h3C}, {12'hFFF, 8'hA5}, {12'h7A5, 8'h00},
    {12'h01F, 8'hFF}, {12'h800, 8'h5A}, {12'h123, 8'hC3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic wr_permit = 1'b1;
  logic sda_oe, mem_we;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic sda_line;
  logic [7:0] arr [4096];
  logic [7:0] exp_mem [4096];
  int total = 0, bad = 0, we_count = 0, viol = 0, scl_hi = 0;
  logic oe_prev = 1'b0;

  always #5 clk = ~clk;

  assign sda_line  = m_sda & ~sda_oe;
  assign mem_rdata = arr[mem_addr];

  twi_eep_slave #(.WRITE_CYCLES(WCYC)) i_twi_eep_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_sel(STRAP), .wr_permit(wr_permit),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] init_byte(input int i);
    return 8'((i * 7) + (i >> 4)) ^ 8'h5A;
  endfunction

  initial begin
    for (int i = 0; i < 4096; i++) begin
      arr[i] = init_byte(i);
      exp_mem[i] = init_byte(i);
    end
  end

  always @(posedge clk) begin
    if (mem_we) arr[mem_addr] <= mem_wdata;
    if (rst_n && mem_we) we_count <= we_count + 1;
  end

  // R9 monitor: sda_oe must not move during a settled SCL-high phase
  always @(negedge clk) begin
    if (m_scl) scl_hi <= scl_hi + 1; else scl_hi <= 0;
    if (sda_oe !== oe_prev && m_scl && scl_hi > 6) viol <= viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_clks(Q);
    m_scl = 1'b1; wait_clks(Q);
    m_sda = 1'b0; wait_clks(Q);
    m_scl = 1'b0; wait_clks(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clks(Q);
    m_scl = 1'b1; wait_clks(Q);
    m_sda = 1'b1; wait_clks(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_clks(Q);
      m_scl = 1'b1; wait_clks(2 * Q);
      m_scl = 1'b0; wait_clks(Q);
    end
    m_sda = 1'b1; wait_clks(Q);
    m_scl = 1'b1; wait_clks(Q);
    ack = !sda_line; wait_clks(Q);
    m_scl = 1'b0; wait_clks(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clks(Q);
      m_scl = 1'b1; wait_clks(Q);
      b[i] = sda_line; wait_clks(Q);
      m_scl = 1'b0; wait_clks(Q);
    end
    m_sda = !mack; wait_clks(Q);
    m_scl = 1'b1; wait_clks(2 * Q);
    m_scl = 1'b0; wait_clks(Q);
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic [2:0] sel, input logic rd);
    return {4'b1010, sel, rd};
  endfunction

  // start + write header; returns count of acknowledged bytes (3 expected)
  task automatic header(input logic [11:0] a, output int acks);
    logic ack;
    acks = 0;
    bus_start();
    send_byte(dev(STRAP, 1'b0), ack); acks += int'(ack);
    send_byte({4'hF, a[11:8]}, ack);  acks += int'(ack);
    send_byte(a[7:0], ack);           acks += int'(ack);
  endtask

  task automatic poll_ready(output int n);
    logic ack;
    n = 0;
    do begin
      bus_start();
      send_byte(dev(STRAP, 1'b0), ack);
      bus_stop();
      n++;
    end while (!ack && n < 200);
  endtask

  task automatic random_read(input logic [11:0] a, output logic [7:0] d, output int acks);
    logic ack;
    header(a, acks);
    bus_start();
    send_byte(dev(STRAP, 1'b1), ack); acks += int'(ack);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    int acks, polls, we0;
    logic ack;
    logic [7:0] d;
    // reset state (R1)
    wait_clks(10);
    check("R1 sda_oe in reset", sda_oe, 0);
    check("R1 mem_we in reset", mem_we, 0);
    rst_n = 1'b1;
    wait_clks(30);
    check("R1 sda_oe idle", sda_oe, 0);
    check("R1 no writes idle", we_count, 0);

    // vector table: byte write, poll, random read (R3 R5 R6)
    for (int v = 0; v < NVEC; v++) begin
      logic [11:0] va;
      logic [7:0]  vd;
      va = VEC[v][19:8];
      vd = VEC[v][7:0];
      header(va, acks);
      send_byte(vd, ack); acks += int'(ack);
      check("R3 write acks", acks, 4);
      check("R3 no array write before stop", arr[va], exp_mem[va]);
      bus_stop();
      exp_mem[va] = vd;
      poll_ready(polls);
      check("R5 busy window seen", 32'(polls > 1), 1);
      random_read(va, d, acks);
      check("R6 random read acks", acks, 4);
      check("R6 random read data", d, vd);
    end

    // address mismatch (R2)
    we0 = we_count;
    bus_start();
    send_byte(dev(3'b010, 1'b0), ack);
    check("R2 wrong strap nack", ack, 0);
    send_byte(8'h00, ack);
    check("R2 silent after mismatch", ack, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b1}, ack);
    check("R2 wrong prefix nack", ack, 0);
    bus_stop();
    check("R2 no array write", we_count, we0);

    // page write of 34 bytes from slot 16 of page 0x2E0 (R4 R5)
    we0 = we_count;
    header(12'h2F0, acks);
    for (int k = 0; k < 34; k++) begin
      send_byte(8'(8'h40 + k), ack); acks += int'(ack);
    end
    check("R4 page acks", acks, 37);
    check("R5 no write before stop", we_count, we0);
    bus_stop();
    for (int k = 0; k < 34; k++) exp_mem[12'h2E0 + ((16 + k) % 32)] = 8'(8'h40 + k);
    bus_start();
    send_byte(dev(STRAP, 1'b0), ack);
    check("R5 nack during commit", ack, 0);
    bus_stop();
    poll_ready(polls);
    check("R5 ack after commit", 32'(polls < 200), 1);
    check("R4 each slot stored once", we_count - we0, 32);

    // current-address read continues after the page write (R6)
    bus_start();
    send_byte(dev(STRAP, 1'b1), ack);
    check("R6 read dev ack", ack, 1);
    recv_byte(1'b0, d);
    bus_stop();
    check("R6 current address data", d, exp_mem[12'h2F2]);

    // sequential read over the whole page (R4 R7)
    header(12'h2E0, acks);
    bus_start();
    send_byte(dev(STRAP, 1'b1), ack);
    for (int k = 0; k < 32; k++) begin
      recv_byte(k != 31, d);
      check("R4 page contents", d, exp_mem[12'h2E0 + k]);
    end
    bus_stop();
    random_read(12'h300, d, acks);
    check("R4 next page untouched", d, exp_mem[12'h300]);
    random_read(12'h2DF, d, acks);
    check("R4 previous page untouched", d, exp_mem[12'h2DF]);

    // sequential read wrapping 0xFFF -> 0x000 (R7)
    header(12'hFFE, acks);
    bus_start();
    send_byte(dev(STRAP, 1'b1), ack);
    recv_byte(1'b1, d);
    check("R7 seq byte FFE", d, exp_mem[12'hFFE]);
    recv_byte(1'b1, d);
    check("R7 seq byte FFF", d, exp_mem[12'hFFF]);
    recv_byte(1'b0, d);
    check("R7 seq wrap to 000", d, exp_mem[12'h000]);
    bus_stop();
    check("R7 released after nack", sda_oe, 0);

    // write refused by protection (R8)
    we0 = we_count;
    wr_permit = 1'b0;
    header(12'h444, acks);
    send_byte(8'h99, ack); acks += int'(ack);
    bus_stop();
    check("R8 refused write still acked", acks, 4);
    bus_start();
    send_byte(dev(STRAP, 1'b0), ack);
    bus_stop();
    check("R8 no busy window", ack, 1);
    wait_clks(WCYC + 50);
    check("R8 no array write", we_count, we0);
    wr_permit = 1'b1;
    random_read(12'h444, d, acks);
    check("R8 array unchanged", d, exp_mem[12'h444]);

    // open-drain discipline over the whole run (R9)
    check("R9 sda_oe moved while SCL high", viol, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule